// File: doc/BRIEF.md
# Load-Store Data Alignment Unit

This block sits between a 32-bit core and a byte-addressed data memory. On the request side it forms the effective address from a base register and a signed 16-bit displacement. For stores it places the store data onto the byte lanes the access covers and produces a per-lane write-enable mask. It raises a flag when an access is not aligned to its own size. On the response side it takes the 32-bit word read back from memory, the low address bits and the access type. It returns the addressed byte or halfword extended to 32 bits, or the whole word unchanged.

The two paths are independent. Each has one register stage: a request accepted on a clock edge appears on the memory-side outputs after that edge, and a read response accepted on an edge appears on the load-result outputs after that edge. Lane numbering is big-endian. Address offset 0 is data bits 31..24 and enable bit 3; offset 3 is bits 7..0 and enable bit 0. Access size codes: 0 = byte, 1 = halfword, 2 = word, 3 = reserved and handled as word.

Top module: `lsu_align`

## Requirements
- R1: One cycle after `req_valid_i`, `mem_addr_o` equals `req_base_i` plus `req_disp_i` sign-extended to 32 bits, taken modulo 2^32.
- R2: A byte store (size 0) drives the low byte of `req_wdata_i` on all four lanes. It enables exactly one lane, `mem_be_o = 4'b1000 >> offset`, where offset is bits 1..0 of the effective address.
- R3: A halfword store (size 1) drives the low 16 bits of `req_wdata_i` on both halves. With offset 0 it enables `4'b1100`, and with offset 2 it enables `4'b0011`.
- R4: A word store (size 2, or reserved size 3) at offset 0 passes `req_wdata_i` through unchanged with `mem_be_o = 4'b1111`.
- R5: A halfword access with offset bit 0 set, or a word access with a nonzero offset, sets `misalign_o` and forces `mem_be_o` to 0. A byte access never sets `misalign_o`.
- R6: A word load (size 2 or 3) returns `rsp_rdata_i` unchanged on `ld_data_o` one cycle after `rsp_valid_i`.
- R7: A byte load returns the byte at `rsp_off_i` (offset 0 = bits 31..24). It is zero-extended when `rsp_unsigned_i` is 1 and sign-extended when it is 0.
- R8: A halfword load returns bits 31..16 when `rsp_off_i[1]` is 0 and bits 15..0 when it is 1, with `rsp_off_i[0]` ignored. It is extended as in R7.
- R9: `mem_we_o` follows `req_store_i`. A load request produces the same lane mask and misalign flag as a store of the same size and address.
- R10: While `rst_ni` is low, `mem_valid_o`, `ld_valid_o`, `mem_be_o`, `misalign_o`, `mem_addr_o` and `ld_data_o` are 0.
- R11: A request and a read response accepted in the same cycle both produce their results one cycle later, neither affecting the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_size_i | input | 2 | Access size code |
| req_base_i | input | 32 | Base register value |
| req_disp_i | input | 16 | Signed displacement |
| req_wdata_i | input | 32 | Store data, right-justified |
| mem_valid_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 32 | Effective byte address |
| mem_be_o | output | 4 | Lane enables, bit 3 = offset 0 |
| mem_wdata_o | output | 32 | Lane-placed store data |
| misalign_o | output | 1 | Access not aligned to its size |
| rsp_valid_i | input | 1 | Read word present this cycle |
| rsp_unsigned_i | input | 1 | 1 = zero-extend, 0 = sign-extend |
| rsp_size_i | input | 2 | Access size code of the load |
| rsp_off_i | input | 2 | Low address bits of the load |
| rsp_rdata_i | input | 32 | Word read from memory |
| ld_valid_o | output | 1 | Load result valid |
| ld_data_o | output | 32 | Aligned and extended load result |

## Verification
A new request (address, lane mask and store-data placement) and a returning read word (lane select and extension) can arrive in the same cycle. The bench provokes this by driving a misaligned halfword store together with a signed byte load whose selected byte has its top bit set. It also drives a word store together with an unsigned halfword load. Both results are expected on the next edge, and each is checked against its own scoreboard queue. A mix-up between the two paths, or a stall in either one, therefore shows up as a mismatch or as a leftover queue entry.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;

  assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
  assign addr_o   = base_i + disp_ext;
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  acc_size_e                       size_i,
  input  logic [$clog2(DATA_W/8)-1:0]     off_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [DATA_W/8-1:0]             be_o,
  output logic [DATA_W-1:0]               wdata_o,
  output logic                            misalign_o
);
  localparam int NB    = DATA_W / 8;
  localparam int HB    = NB / 2;
  localparam int OFF_W = $clog2(NB);

  always_comb begin
    unique case (size_i)
      SZ_BYTE: misalign_o = 1'b0;
      SZ_HALF: misalign_o = off_i[0];
      default: misalign_o = |off_i;
    endcase
  end

  always_comb begin
    unique case (size_i)
      SZ_BYTE: wdata_o = {NB{wdata_i[7:0]}};
      SZ_HALF: wdata_o = {HB{wdata_i[15:0]}};
      default: wdata_o = wdata_i;
    endcase
  end

  // enable bit i carries data bits 8i+7..8i; big-endian offset = NB-1-i
  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam logic [OFF_W-1:0] LANE_OFF = OFF_W'(NB - 1 - i);
    logic hit;

    always_comb begin
      unique case (size_i)
        SZ_BYTE: hit = (off_i == LANE_OFF);
        SZ_HALF: hit = (off_i[OFF_W-1:1] == LANE_OFF[OFF_W-1:1]);
        default: hit = 1'b1;
      endcase
    end

    assign be_o[i] = hit & ~misalign_o;
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  acc_size_e                   size_i,
  input  logic [$clog2(DATA_W/8)-1:0] off_i,
  input  logic                        uns_i,
  input  logic [DATA_W-1:0]           rdata_i,
  output logic [DATA_W-1:0]           data_o
);
  localparam int NB    = DATA_W / 8;
  localparam int HB    = NB / 2;
  localparam int OFF_W = $clog2(NB);

  logic [7:0]  byte_sel;
  logic [15:0] half_sel;

  always_comb begin
    byte_sel = '0;
    for (int k = 0; k < NB; k++) begin
      if (off_i == OFF_W'(k)) byte_sel = rdata_i[DATA_W-1-8*k -: 8];
    end
  end

  // halfword lane from upper offset bits only
  always_comb begin
    half_sel = '0;
    for (int j = 0; j < HB; j++) begin
      if (off_i[OFF_W-1:1] == (OFF_W-1)'(j)) half_sel = rdata_i[DATA_W-1-16*j -: 16];
    end
  end

  always_comb begin
    unique case (size_i)
      SZ_BYTE: data_o = {{(DATA_W-8){byte_sel[7] & ~uns_i}}, byte_sel};
      SZ_HALF: data_o = {{(DATA_W-16){half_sel[15] & ~uns_i}}, half_sel};
      default: data_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/lsu_align.sv
module lsu_align
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic [1:0]        req_size_i,
  input  logic [ADDR_W-1:0] req_base_i,
  input  logic [DISP_W-1:0] req_disp_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [NB-1:0]     mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              misalign_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_unsigned_i,
  input  logic [1:0]        rsp_size_i,
  input  logic [OFF_W-1:0]  rsp_off_i,
  input  logic [DATA_W-1:0] rsp_rdata_i,
  output logic              ld_valid_o,
  output logic [DATA_W-1:0] ld_data_o
);
  logic [ADDR_W-1:0] ea;
  logic [NB-1:0]     be_d;
  logic [DATA_W-1:0] wdata_d;
  logic              mis_d;
  logic [DATA_W-1:0] ld_d;

  lsu_addr_gen #(
    .ADDR_W(ADDR_W),
    .DISP_W(DISP_W)
  ) u_addr (
    .base_i (req_base_i),
    .disp_i (req_disp_i),
    .addr_o (ea)
  );

  lsu_store_lanes #(
    .DATA_W(DATA_W)
  ) u_lanes (
    .size_i     (acc_size_e'(req_size_i)),
    .off_i      (ea[OFF_W-1:0]),
    .wdata_i    (req_wdata_i),
    .be_o       (be_d),
    .wdata_o    (wdata_d),
    .misalign_o (mis_d)
  );

  lsu_load_extract #(
    .DATA_W(DATA_W)
  ) u_extract (
    .size_i  (acc_size_e'(rsp_size_i)),
    .off_i   (rsp_off_i),
    .uns_i   (rsp_unsigned_i),
    .rdata_i (rsp_rdata_i),
    .data_o  (ld_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_valid_o <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_be_o    <= '0;
      mem_wdata_o <= '0;
      misalign_o  <= 1'b0;
    end else begin
      mem_valid_o <= req_valid_i;
      if (req_valid_i) begin
        mem_we_o    <= req_store_i;
        mem_addr_o  <= ea;
        mem_be_o    <= be_d;
        mem_wdata_o <= wdata_d;
        misalign_o  <= mis_d;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_valid_o <= 1'b0;
      ld_data_o  <= '0;
    end else begin
      ld_valid_o <= rsp_valid_i;
      if (rsp_valid_i) ld_data_o <= ld_d;
    end
  end
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_store_i,
  input logic [1:0]        req_size_i,
  input logic [ADDR_W-1:0] req_base_i,
  input logic [DISP_W-1:0] req_disp_i,
  input logic [DATA_W-1:0] req_wdata_i,
  input logic              mem_valid_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [NB-1:0]     mem_be_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              misalign_o,
  input logic              rsp_valid_i,
  input logic              rsp_unsigned_i,
  input logic [1:0]        rsp_size_i,
  input logic [OFF_W-1:0]  rsp_off_i,
  input logic [DATA_W-1:0] rsp_rdata_i,
  input logic              ld_valid_o,
  input logic [DATA_W-1:0] ld_data_o
);
  p_ea_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> mem_addr_o == $past(req_base_i + {{(ADDR_W-DISP_W){req_disp_i[DISP_W-1]}}, req_disp_i}));

  p_byte_one_lane_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_size_i == 2'd0) |=> ($countones(mem_be_o) == 1 && !misalign_o));

  p_mis_no_be_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && misalign_o) |-> mem_be_o == '0);

  p_word_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && rsp_size_i[1]) |=> ld_data_o == $past(rsp_rdata_i));

  p_we_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> mem_we_o == $past(req_store_i));

  p_both_paths_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && rsp_valid_i) |=> (mem_valid_o && ld_valid_o));

  always_comb begin
    if (!rst_ni) begin
      a_reset_r10: assert (!mem_valid_o && !ld_valid_o && mem_be_o == '0);
    end
  end
endmodule

bind lsu_align lsu_align_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W),
  .DISP_W(DISP_W)
) u_chk (.*);

// File: tb/lsu_align_tb_top.sv
module lsu_align_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        req_valid_i, req_store_i;
  logic [1:0]  req_size_i;
  logic [31:0] req_base_i;
  logic [15:0] req_disp_i;
  logic [31:0] req_wdata_i;
  logic        mem_valid_o, mem_we_o, misalign_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [3:0]  mem_be_o;
  logic        rsp_valid_i, rsp_unsigned_i;
  logic [1:0]  rsp_size_i, rsp_off_i;
  logic [31:0] rsp_rdata_i;
  logic        ld_valid_o;
  logic [31:0] ld_data_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // request scoreboard
  logic [31:0] q_addr[$];
  logic [3:0]  q_be[$];
  logic [31:0] q_wd[$];
  logic        q_mis[$];
  logic        q_we[$];
  string       q_tag[$];
  // load scoreboard
  logic [31:0] q_ld[$];
  string       q_ltag[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lsu_align dut_i (.*);

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_be(logic [1:0] sz, logic [1:0] off);
    case (sz)
      2'd0:    return 4'b1000 >> off;
      2'd1:    return off[0] ? 4'b0000 : (off[1] ? 4'b0011 : 4'b1100);
      default: return (off != 2'd0) ? 4'b0000 : 4'b1111;
    endcase
  endfunction

  function automatic logic exp_mis(logic [1:0] sz, logic [1:0] off);
    case (sz)
      2'd0:    return 1'b0;
      2'd1:    return off[0];
      default: return off != 2'd0;
    endcase
  endfunction

  function automatic logic [31:0] exp_wd(logic [1:0] sz, logic [31:0] wd);
    case (sz)
      2'd0:    return {wd[7:0], wd[7:0], wd[7:0], wd[7:0]};
      2'd1:    return {wd[15:0], wd[15:0]};
      default: return wd;
    endcase
  endfunction

  function automatic logic [31:0] exp_load(logic [1:0] sz, logic uns, logic [1:0] off, logic [31:0] rd);
    logic [7:0]  b;
    logic [15:0] h;
    case (off)
      2'd0: b = rd[31:24];
      2'd1: b = rd[23:16];
      2'd2: b = rd[15:8];
      default: b = rd[7:0];
    endcase
    h = off[1] ? rd[15:0] : rd[31:16];
    case (sz)
      2'd0:    return uns ? {24'h0, b} : {{24{b[7]}}, b};
      2'd1:    return uns ? {16'h0, h} : {{16{h[15]}}, h};
      default: return rd;
    endcase
  endfunction

  task automatic set_req(bit st, logic [1:0] sz, logic [31:0] base, logic [15:0] disp,
                         logic [31:0] wd, string tag);
    logic [31:0] ea;
    ea = base + {{16{disp[15]}}, disp};
    req_valid_i = 1'b1; req_store_i = st; req_size_i = sz;
    req_base_i = base; req_disp_i = disp; req_wdata_i = wd;
    q_addr.push_back(ea);
    q_be.push_back(exp_be(sz, ea[1:0]));
    q_wd.push_back(exp_wd(sz, wd));
    q_mis.push_back(exp_mis(sz, ea[1:0]));
    q_we.push_back(st);
    q_tag.push_back(tag);
  endtask

  task automatic set_rsp(logic [1:0] sz, logic uns, logic [1:0] off, logic [31:0] rd, string tag);
    rsp_valid_i = 1'b1; rsp_size_i = sz; rsp_unsigned_i = uns;
    rsp_off_i = off; rsp_rdata_i = rd;
    q_ld.push_back(exp_load(sz, uns, off, rd));
    q_ltag.push_back(tag);
  endtask

  task automatic step();
    @(negedge clk_i);
    req_valid_i = 1'b0;
    rsp_valid_i = 1'b0;
  endtask

  task automatic req(bit st, logic [1:0] sz, logic [31:0] base, logic [15:0] disp,
                     logic [31:0] wd, string tag);
    set_req(st, sz, base, disp, wd, tag);
    step();
  endtask

  task automatic ld(logic [1:0] sz, logic uns, logic [1:0] off, logic [31:0] rd, string tag);
    set_rsp(sz, uns, off, rd, tag);
    step();
  endtask

  // monitor
  always @(posedge clk_i) begin
    #1;
    if (rst_ni && mem_valid_o) begin
      if (q_addr.size() == 0) begin
        chk("R9", "unexpected mem_valid_o", 32'd1, 32'd0);
      end else begin
        logic [31:0] a, w;
        logic [3:0]  be;
        logic        m, we;
        string       t;
        a = q_addr.pop_front(); be = q_be.pop_front(); w = q_wd.pop_front();
        m = q_mis.pop_front(); we = q_we.pop_front(); t = q_tag.pop_front();
        chk("R1", "mem_addr_o", mem_addr_o, a);
        chk("R9", "mem_we_o", {31'd0, mem_we_o}, {31'd0, we});
        chk(t, "mem_be_o", {28'd0, mem_be_o}, {28'd0, be});
        chk("R5", "misalign_o", {31'd0, misalign_o}, {31'd0, m});
        if (we && !m) chk(t, "mem_wdata_o", mem_wdata_o, w);
      end
    end
    if (rst_ni && ld_valid_o) begin
      if (q_ld.size() == 0) begin
        chk("R11", "unexpected ld_valid_o", 32'd1, 32'd0);
      end else begin
        logic [31:0] e;
        string       t;
        e = q_ld.pop_front(); t = q_ltag.pop_front();
        chk(t, "ld_data_o", ld_data_o, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0;
    req_valid_i = 0; req_store_i = 0; req_size_i = 0; req_base_i = 0;
    req_disp_i = 0; req_wdata_i = 0;
    rsp_valid_i = 0; rsp_unsigned_i = 0; rsp_size_i = 0; rsp_off_i = 0; rsp_rdata_i = 0;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10", "mem_valid_o", {31'd0, mem_valid_o}, 32'd0);
    chk("R10", "ld_valid_o", {31'd0, ld_valid_o}, 32'd0);
    chk("R10", "mem_be_o", {28'd0, mem_be_o}, 32'd0);
    chk("R10", "misalign_o", {31'd0, misalign_o}, 32'd0);
    chk("R10", "mem_addr_o", mem_addr_o, 32'd0);
    chk("R10", "ld_data_o", ld_data_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 address forms, incl. negative displacement and wrap
    req(1'b0, 2'd2, 32'h1000_0000, 16'h0010, 32'h0, "R4");
    req(1'b0, 2'd2, 32'h1000_0000, 16'hFFFC, 32'h0, "R4");
    req(1'b0, 2'd0, 32'h0000_0002, 16'h8000, 32'h0, "R2");
    req(1'b0, 2'd2, 32'hFFFF_FFF0, 16'h0010, 32'h0, "R4");

    // R2 byte stores at every offset
    for (int k = 0; k < 4; k++) req(1'b1, 2'd0, 32'h2000_0000 + k, 16'h0, 32'hDEAD_BE5A, "R2");
    // R3 halfword stores at aligned offsets, R5 odd offsets
    req(1'b1, 2'd1, 32'h2000_0000, 16'h0000, 32'h1234_A5C3, "R3");
    req(1'b1, 2'd1, 32'h2000_0000, 16'h0002, 32'h1234_A5C3, "R3");
    req(1'b1, 2'd1, 32'h2000_0001, 16'h0000, 32'h1234_A5C3, "R5");
    req(1'b1, 2'd1, 32'h2000_0000, 16'h0003, 32'h1234_A5C3, "R5");
    // R4 word store, reserved size, R5 misaligned words
    req(1'b1, 2'd2, 32'h3000_0000, 16'h0008, 32'hCAFE_F00D, "R4");
    req(1'b1, 2'd3, 32'h3000_0000, 16'h0004, 32'h0BAD_CAFE, "R4");
    for (int k = 1; k < 4; k++) req(1'b1, 2'd2, 32'h3000_0000, 16'(k), 32'hCAFE_F00D, "R5");
    // R9 loads give masks like stores
    req(1'b0, 2'd0, 32'h4000_0003, 16'h0, 32'hFFFF_FFFF, "R9");
    req(1'b0, 2'd1, 32'h4000_0002, 16'h0, 32'hFFFF_FFFF, "R9");
    req(1'b0, 2'd1, 32'h4000_0001, 16'h0, 32'hFFFF_FFFF, "R5");

    // R6 word loads
    ld(2'd2, 1'b0, 2'd0, 32'h8123_4567, "R6");
    ld(2'd3, 1'b1, 2'd0, 32'hF0E1_D2C3, "R6");
    // R7 byte loads at every offset, both extensions
    for (int k = 0; k < 4; k++) begin
      ld(2'd0, 1'b0, 2'(k), 32'h80_7F_C1_05, "R7");
      ld(2'd0, 1'b1, 2'(k), 32'h80_7F_C1_05, "R7");
    end
    // R8 halfword loads, offset bit 0 ignored
    for (int k = 0; k < 4; k++) begin
      ld(2'd1, 1'b0, 2'(k), 32'h9ABC_7123, "R8");
      ld(2'd1, 1'b1, 2'(k), 32'h9ABC_7123, "R8");
    end
    ld(2'd1, 1'b0, 2'd2, 32'h1234_8001, "R8");

    // R11 same-cycle request and response
    set_req(1'b1, 2'd1, 32'h5000_0001, 16'h0, 32'h0000_BEEF, "R11");
    set_rsp(2'd0, 1'b0, 2'd2, 32'h0011_9922, "R11");
    step();
    set_req(1'b1, 2'd2, 32'h5000_0000, 16'h0, 32'h7654_3210, "R11");
    set_rsp(2'd1, 1'b1, 2'd0, 32'hFEDC_0000, "R11");
    step();
    set_req(1'b0, 2'd0, 32'h5000_0001, 16'h0, 32'h0, "R11");
    set_rsp(2'd2, 1'b0, 2'd0, 32'h0000_0001, "R11");
    step();

    repeat (4) @(negedge clk_i);
    chk("R11", "request queue left", 32'(q_addr.size()), 32'd0);
    chk("R11", "load queue left", 32'(q_ld.size()), 32'd0);
    finish_run();
  end
endmodule